// File: doc/BRIEF.md
# Countdown ECC Fault Injection Unit

This unit sits in the write-data path of an ECC-protected memory and corrupts one data word on purpose, so that the error-detection logic further down the path can be tested. Software sets up a 64-bit flip mask as two 32-bit halves and then loads a 24-bit countdown over a small register bus. Loading the countdown arms the unit. Each memory write access taken while the unit is armed lowers the countdown by one. When an access arrives with the countdown already at zero, the mask is XORed into that access's data word and the unit disarms. All later writes pass through unchanged.

A mask with one bit set gives a correctable error in the codec. A mask with two different bits set gives an uncorrectable one. The register interface reads back both mask halves, the remaining count and an armed flag. A test can therefore poll the armed flag to find out when the injection has taken place. The output data path is combinational, so the unit adds no cycle of latency to the memory write.

Top module: `ecc_fault_inject`

## Requirements
- R1: After reset the unit is disarmed, both mask halves read 0, the count reads 0, and `mem_wdata_out` equals `mem_wdata_in` on every write access.
- R2: A register write to address 0x00 stores mask bits 31:0 and a write to 0x04 stores mask bits 63:32. Reading the same addresses returns the stored halves.
- R3: A register write to address 0x08 loads the countdown with `reg_wdata[23:0]` and discards bits 31:24. Reading 0x08 returns the count in bits 23:0 and zeros above.
- R4: A register write to 0x08 arms the unit. Reading the status address 0x0C returns the armed flag in bit 0 and zeros above.
- R5: While the unit is armed, a write access with a nonzero count lowers the count by one and passes the data through unmodified.
- R6: A write access that arrives while the unit is armed and the count is zero outputs `mem_wdata_in ^ mask` in that same cycle. From the next cycle the unit is disarmed. A one-bit mask flips exactly one bit and a two-bit mask flips exactly two.
- R7: Once the unit is disarmed, write accesses pass through unmodified and the count stays at 0.
- R8: Writes to the mask registers never arm the unit. While it is armed, they leave the count and the armed flag unchanged.
- R9: Cycles without a write access leave the count and the armed flag unchanged.
- R10: In a cycle where a count-register write and a memory write access coincide, the register write wins. The count takes the new value and that access is neither counted nor corrupted.
- R11: Register writes to unmapped addresses change no state, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address, used for writes and for the combinational read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_wr | input | 1 | Memory write access in this cycle |
| mem_wdata_in | input | 64 | Write data arriving from the requester |
| mem_wdata_out | output | 64 | Write data sent to the ECC encoder, possibly corrupted |

## Verification
The hardest situation to reach from the ports is the exact access on which the count is zero. Reaching it depends on every earlier access being counted correctly, including idle cycles between accesses and a reload that coincides with an access. The stimulus arms the unit with a small count that has junk in the discarded upper bits. It then issues accesses one at a time with idle gaps and reads the count back after each one, so it knows the expected injection cycle in advance. A separate case makes a count-register write and an access fall in the same cycle while a zero count is armed. That access must pass clean and the new count must hold.

// File: rtl/fi_pkg.sv
package fi_pkg;
  typedef enum logic {
    FI_IDLE  = 1'b0,
    FI_ARMED = 1'b1
  } fi_state_e;
endpackage

// File: rtl/fi_rst_sync.sv
module fi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/fi_regs.sv
module fi_regs #(
  parameter int DATA_W   = 64,
  parameter int REG_W    = 32,
  parameter int ADDR_W   = 8,
  parameter int CNT_W    = 24,
  parameter int ADDR_CNT = 8,
  parameter int ADDR_STS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              armed,
  output logic [DATA_W-1:0] pattern,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_load_val,
  output logic [REG_W-1:0]  reg_rdata
);
  localparam int NWORDS = DATA_W / REG_W;
  localparam int BYTES  = REG_W / 8;

  logic [NWORDS-1:0] word_hit;

  genvar gi;
  generate
    for (gi = 0; gi < NWORDS; gi++) begin : g_word
      logic [REG_W-1:0] word_q;
      logic [REG_W-1:0] word_d;
      logic             word_en;

      assign word_hit[gi] = (reg_addr == ADDR_W'(gi * BYTES));
      assign word_en      = reg_wr && word_hit[gi];

      always_comb begin
        word_d = word_q;
        if (word_en) begin
          word_d = reg_wdata;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          word_q <= '0;
        end else if (word_en) begin
          word_q <= word_d;
        end
      end

      assign pattern[gi*REG_W +: REG_W] = word_q;
    end
  endgenerate

  assign cnt_load     = reg_wr && (reg_addr == ADDR_W'(ADDR_CNT));
  assign cnt_load_val = reg_wdata[CNT_W-1:0];

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NWORDS; i++) begin
      if (word_hit[i]) begin
        reg_rdata = pattern[i*REG_W +: REG_W];
      end
    end
    if (reg_addr == ADDR_W'(ADDR_CNT)) begin
      reg_rdata = REG_W'(count);
    end
    if (reg_addr == ADDR_W'(ADDR_STS)) begin
      reg_rdata = REG_W'(armed);
    end
  end
endmodule

// File: rtl/fi_countdown.sv
module fi_countdown
  import fi_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_load_val,
  input  logic             access,
  output logic             armed,
  output logic [CNT_W-1:0] count,
  output logic             fire
);
  fi_state_e        state_q, state_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             upd_en;
  logic             at_zero;

  assign at_zero = (count_q == '0);

  always_comb begin
    state_d = state_q;
    count_d = count_q;
    fire    = 1'b0;
    if (cnt_load) begin
      state_d = FI_ARMED;
      count_d = cnt_load_val;
    end else if (state_q == FI_ARMED && access) begin
      if (at_zero) begin
        fire    = 1'b1;
        state_d = FI_IDLE;
      end else begin
        count_d = count_q - CNT_W'(1);
      end
    end
  end

  assign upd_en = cnt_load || (access && state_q == FI_ARMED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FI_IDLE;
      count_q <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      count_q <= count_d;
    end
  end

  assign armed = (state_q == FI_ARMED);
  assign count = count_q;
endmodule

// File: rtl/fi_datapath.sv
module fi_datapath #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 32
) (
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] pattern,
  input  logic              fire,
  output logic [DATA_W-1:0] dout
);
  localparam int NLANES = DATA_W / LANE_W;

  genvar gl;
  generate
    for (gl = 0; gl < NLANES; gl++) begin : g_lane
      logic [LANE_W-1:0] mask;
      assign mask = fire ? pattern[gl*LANE_W +: LANE_W] : '0;
      assign dout[gl*LANE_W +: LANE_W] = din[gl*LANE_W +: LANE_W] ^ mask;
    end
  endgenerate
endmodule

// File: rtl/ecc_fault_inject.sv
module ecc_fault_inject #(
  parameter int DATA_W   = 64,
  parameter int REG_W    = 32,
  parameter int ADDR_W   = 8,
  parameter int CNT_W    = 24,
  parameter int ADDR_CNT = 8,
  parameter int ADDR_STS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              mem_wr,
  input  logic [DATA_W-1:0] mem_wdata_in,
  output logic [DATA_W-1:0] mem_wdata_out
);
  logic              rst_sync_n;
  logic [DATA_W-1:0] pattern_w;
  logic              cnt_load_w;
  logic [CNT_W-1:0]  cnt_load_val_w;
  logic [CNT_W-1:0]  count_w;
  logic              armed_w;
  logic              fire_w;

  fi_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fi_regs #(
    .DATA_W   (DATA_W),
    .REG_W    (REG_W),
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .ADDR_CNT (ADDR_CNT),
    .ADDR_STS (ADDR_STS)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .count        (count_w),
    .armed        (armed_w),
    .pattern      (pattern_w),
    .cnt_load     (cnt_load_w),
    .cnt_load_val (cnt_load_val_w),
    .reg_rdata    (reg_rdata)
  );

  fi_countdown #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .cnt_load     (cnt_load_w),
    .cnt_load_val (cnt_load_val_w),
    .access       (mem_wr),
    .armed        (armed_w),
    .count        (count_w),
    .fire         (fire_w)
  );

  fi_datapath #(
    .DATA_W (DATA_W),
    .LANE_W (REG_W)
  ) u_dp (
    .din     (mem_wdata_in),
    .pattern (pattern_w),
    .fire    (fire_w),
    .dout    (mem_wdata_out)
  );
endmodule

// File: rtl/ecc_fault_inject_chk.sv
module ecc_fault_inject_chk #(
  parameter int DATA_W   = 64,
  parameter int REG_W    = 32,
  parameter int ADDR_W   = 8,
  parameter int CNT_W    = 24,
  parameter int ADDR_CNT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              mem_wr,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout,
  input logic              armed,
  input logic [CNT_W-1:0]  count
);
  logic ld;
  assign ld = reg_wr && (reg_addr == ADDR_W'(ADDR_CNT));

  assert_arm_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (armed && count == $past(reg_wdata[CNT_W-1:0])));

  assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && mem_wr && !ld && count != '0) |=> (armed && count == $past(count) - CNT_W'(1)));

  assert_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && mem_wr && !ld && count == '0) |=> !armed);

  assert_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed || !mem_wr) |-> (dout == din));

  assert_no_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !ld) |=> !armed);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr && !ld) |=> ($stable(count) && $stable(armed)));

  assert_collision_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && mem_wr) |-> (dout == din));
endmodule

bind ecc_fault_inject ecc_fault_inject_chk #(
  .DATA_W   (DATA_W),
  .REG_W    (REG_W),
  .ADDR_W   (ADDR_W),
  .CNT_W    (CNT_W),
  .ADDR_CNT (ADDR_CNT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .mem_wr    (mem_wr),
  .din       (mem_wdata_in),
  .dout      (mem_wdata_out),
  .armed     (armed_w),
  .count     (count_w)
);

// File: tb/tb_ecc_fault_inject.sv
module tb_ecc_fault_inject;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mem_wr;
  logic [63:0] mem_wdata_in;
  logic [63:0] mem_wdata_out;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  ecc_fault_inject dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .mem_wr        (mem_wr),
    .mem_wdata_in  (mem_wdata_in),
    .mem_wdata_out (mem_wdata_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic mem_access(input logic [63:0] din, output logic [63:0] dout);
    @(negedge clk);
    mem_wr = 1'b1; mem_wdata_in = din;
    #1 dout = mem_wdata_out;
    @(posedge clk); #1;
    mem_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] r; logic [63:0] o;
    reg_read(8'h00, r); chk("R1 mask lo", 64'(r), 64'h0);
    reg_read(8'h04, r); chk("R1 mask hi", 64'(r), 64'h0);
    reg_read(8'h08, r); chk("R1 count", 64'(r), 64'h0);
    reg_read(8'h0C, r); chk("R1 status", 64'(r), 64'h0);
    mem_access(64'h0123_4567_89AB_CDEF, o);
    chk("R1 passthrough", o, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_mask_regs();
    logic [31:0] r;
    reg_write(8'h00, 32'hA5A5_0001);
    reg_write(8'h04, 32'h8000_5A5A);
    reg_read(8'h00, r); chk("R2 mask lo readback", 64'(r), 64'hA5A5_0001);
    reg_read(8'h04, r); chk("R2 mask hi readback", 64'(r), 64'h8000_5A5A);
    reg_read(8'h0C, r); chk("R8 mask write no arm", 64'(r), 64'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] r;
    reg_write(8'h20, 32'hFFFF_FFFF);
    reg_read(8'h20, r); chk("R11 unmapped read", 64'(r), 64'h0);
    reg_read(8'h00, r); chk("R11 mask lo kept", 64'(r), 64'hA5A5_0001);
    reg_read(8'h0C, r); chk("R11 status kept", 64'(r), 64'h0);
  endtask

  task automatic t_countdown_single();
    logic [31:0] r; logic [63:0] o; logic [63:0] d;
    reg_write(8'h00, 32'h0000_0020);
    reg_write(8'h04, 32'h0000_0000);
    reg_write(8'h08, 32'hFF00_0003);
    reg_read(8'h08, r); chk("R3 count truncated", 64'(r), 64'h3);
    reg_read(8'h0C, r); chk("R4 armed", 64'(r), 64'h1);
    for (int k = 0; k < 3; k++) begin
      d = 64'h1111_0000_0000_0000 + 64'(k);
      mem_access(d, o);
      chk("R5 pass while counting", o, d);
      reg_read(8'h08, r); chk("R5 count decremented", 64'(r), 64'(2 - k));
      idle(3);
      reg_read(8'h08, r); chk("R9 idle holds count", 64'(r), 64'(2 - k));
    end
    reg_write(8'h04, 32'h0000_0000);
    reg_read(8'h0C, r); chk("R8 mask write keeps armed", 64'(r), 64'h1);
    reg_read(8'h08, r); chk("R8 mask write keeps count", 64'(r), 64'h0);
    d = 64'hFFFF_0000_FFFF_0000;
    mem_access(d, o);
    chk("R6 single bit flip", o, d ^ 64'h20);
    chk("R6 one bit differs", 64'($countones(o ^ d)), 64'd1);
    reg_read(8'h0C, r); chk("R6 disarmed", 64'(r), 64'h0);
    mem_access(d, o);
    chk("R7 pass after disarm", o, d);
    reg_read(8'h08, r); chk("R7 count stays zero", 64'(r), 64'h0);
    reg_write(8'h00, 32'h0000_0001);
    reg_read(8'h0C, r); chk("R8 no rearm", 64'(r), 64'h0);
  endtask

  task automatic t_zero_double();
    logic [31:0] r; logic [63:0] o; logic [63:0] d;
    reg_write(8'h00, 32'h0000_0001);
    reg_write(8'h04, 32'h8000_0000);
    reg_write(8'h08, 32'h0000_0000);
    idle(2);
    d = 64'h0F0F_0F0F_F0F0_F0F0;
    mem_access(d, o);
    chk("R6 zero count double flip", o, d ^ 64'h8000_0000_0000_0001);
    chk("R6 two bits differ", 64'($countones(o ^ d)), 64'd2);
    mem_access(d, o);
    chk("R7 second access clean", o, d);
  endtask

  task automatic t_collision();
    logic [31:0] r; logic [63:0] o; logic [63:0] d;
    reg_write(8'h08, 32'h0000_0000);
    d = 64'hDEAD_BEEF_CAFE_F00D;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h08; reg_wdata = 32'h0000_0002;
    mem_wr = 1'b1; mem_wdata_in = d;
    #1 o = mem_wdata_out;
    @(posedge clk); #1;
    reg_wr = 1'b0; mem_wr = 1'b0;
    chk("R10 collision access clean", o, d);
    reg_read(8'h08, r); chk("R10 new count held", 64'(r), 64'h2);
    reg_read(8'h0C, r); chk("R10 still armed", 64'(r), 64'h1);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    mem_wr = 1'b0; mem_wdata_in = '0;
    idle(4);
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_mask_regs();
    t_unmapped();
    t_countdown_single();
    t_zero_double();
    t_collision();
    idle(2);
    finish_run();
  end
endmodule